// File: doc/BRIEF.md
# Field-Masked Alarm and Event Interrupt Unit

This block sits next to a BCD timekeeping counter. It holds two alarm words. One covers seconds, minutes and hours. The other covers month and date. Every alarm field has its own enable bit, and on each one-second tick the block compares only the enabled fields against the current BCD time. When all of them agree, the alarm event is raised. The alarm event and four event pulses from the counter (update acknowledge, second, time, calendar) go into a sticky status register.

Software controls which status bits reach the single level interrupt output. A write-1-to-set enable register and a write-1-to-clear disable register update the mask, and the mask can be read back. A write-1-to-clear command register acknowledges status bits. A read-only valid-entry register flags alarm words that hold out-of-range BCD values.

The register interface is a simple single-cycle word bus. Writes are accepted when `req_i` and `we_i` are both high. Read data is combinational from the address. Word addresses are:

| Address | Register |
|---|---|
| 0 | time alarm |
| 1 | calendar alarm |
| 2 | status |
| 3 | status clear |
| 4 | irq enable |
| 5 | irq disable |
| 6 | mask |
| 7 | valid entry |

Write-only registers read as 0.

Top module: `rtc_alarm_irq_unit`

## Requirements
- R1: After reset the status and mask registers read 0, the alarm words read 0, `irq_o` is low, and the valid-entry register reads 2, because a zero month and a zero date are out of range.
- R2: The time-alarm word uses these fields: seconds in bits 6:0 with its enable at bit 7, minutes in bits 14:8 with its enable at bit 15, and hours in bits 21:16 with its enable at bit 23. All other bits read back as 0, so writing all ones reads back 0x00BFFFFF.
- R3: The calendar-alarm word uses these fields: month in bits 20:16 with its enable at bit 23, and date in bits 29:24 with its enable at bit 31. There is no year field, and all other bits read 0, so writing all ones reads back 0xBF9F0000.
- R4: On a cycle with `tick_i` high, if every enabled field equals the current value, status bit 1 reads set from the next cycle. Disabled fields are not compared. A match without a tick sets nothing.
- R5: When all five field enables are clear, status bit 1 never sets, even if the fields match on a tick.
- R6: Status bits are sticky. Bit 0 records update acknowledge, bit 1 the alarm, bit 2 the second event, bit 3 the time event and bit 4 the calendar event. An input pulse sets its bit one cycle later. The bit stays set after the cause ends, until software clears it.
- R7: Writing 1s to the status-clear register clears the matching status bits, and 0 bits have no effect. If an event arrives in the same cycle as a clear of its bit, the bit stays set.
- R8: Writing 1s to the enable register sets mask bits, and writing 1s to the disable register clears them. Other mask bits are unaffected. The mask reads back at address 6 with the status bit layout.
- R9: `irq_o` is high exactly when some status bit and its mask bit are both set.
- R10: Valid-entry bit 0 is set when any time-alarm field is not valid BCD or is outside its range: seconds or minutes above 59, or hours above 23. Bit 1 is set when the month is outside 1 to 12 or the date is outside 1 to 31. Fields are checked whether or not they are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write enable |
| addr_i | input | ADDR_W | Bus word address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, combinational |
| cur_sec_i | input | 7 | Current BCD seconds |
| cur_min_i | input | 7 | Current BCD minutes |
| cur_hour_i | input | 6 | Current BCD hours |
| cur_mon_i | input | 5 | Current BCD month |
| cur_date_i | input | 6 | Current BCD date |
| tick_i | input | 1 | One-second tick; alarm compare strobe |
| upd_ack_i | input | 1 | Update-acknowledge event pulse |
| sec_ev_i | input | 1 | Second event pulse |
| time_ev_i | input | 1 | Time event pulse |
| cal_ev_i | input | 1 | Calendar event pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench targets the alarm compare with partial enables. It includes a case with only the seconds field enabled while the minutes differ, which a design comparing every field would miss. A calendar-only alarm is also tried, as is a fully matching alarm with no enables, which a design treating "no enables" as "always match" would fire. The bench collides a status clear with a new update-acknowledge event, where a design that lets the clear win would drop the event. It checks that enable and disable writes touch only their own mask bits and that the interrupt falls when its mask bit goes. Readback of all-ones alarm writes and out-of-range BCD values expose a wrong field placement or range limit.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int WORD_W = 32;
  localparam int NUM_EV = 5;
  localparam int NUM_FLD = 5;

  // status bit positions
  localparam int EV_UPD = 0;
  localparam int EV_ALM = 1;
  localparam int EV_SEC = 2;
  localparam int EV_TIM = 3;
  localparam int EV_CAL = 4;

  // word addresses
  localparam int OFS_TALM = 0;
  localparam int OFS_CALM = 1;
  localparam int OFS_STAT = 2;
  localparam int OFS_SCLR = 3;
  localparam int OFS_IEN  = 4;
  localparam int OFS_IDIS = 5;
  localparam int OFS_MASK = 6;
  localparam int OFS_VLD  = 7;

  // field index order in compare arrays: sec, min, hour, month, date
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_MON  = 3;
  localparam int F_DATE = 4;

  localparam logic [WORD_W-1:0] TALM_MASK = 32'h00BF_FFFF;
  localparam logic [WORD_W-1:0] CALM_MASK = 32'hBF9F_0000;

  localparam logic [7:0] FLD_LO [NUM_FLD] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01};
  localparam logic [7:0] FLD_HI [NUM_FLD] = '{8'h59, 8'h59, 8'h23, 8'h12, 8'h31};

  function automatic logic bcd_in_range(input logic [7:0] v, input logic [7:0] lo,
                                        input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NUM_FLD
) (
  input  logic [NF-1:0][7:0] alm_f_i,
  input  logic [NF-1:0][7:0] cur_f_i,
  input  logic [NF-1:0]      en_i,
  input  logic               tick_i,
  output logic               hit_o,
  output logic [NF-1:0]      bad_o
);
  logic [NF-1:0] fld_ok;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign fld_ok[i] = !en_i[i] || (alm_f_i[i] == cur_f_i[i]);
    assign bad_o[i]  = !bcd_in_range(alm_f_i[i], FLD_LO[i], FLD_HI[i]);
  end

  // an all-disabled alarm never matches
  assign hit_o = tick_i && (|en_i) && (&fld_ok);
endmodule

// File: rtl/rtc_evt_status.sv
module rtc_evt_status #(
  parameter int NEV = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NEV-1:0] set_i,
  input  logic [NEV-1:0] clr_i,
  input  logic [NEV-1:0] ien_i,
  input  logic [NEV-1:0] idis_i,
  output logic [NEV-1:0] status_o,
  output logic [NEV-1:0] mask_o,
  output logic           irq_o
);
  logic [NEV-1:0] status_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_i) | set_i;  // set beats clear
      mask_q   <= (mask_q | ien_i) & ~idis_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/rtc_alarm_irq_unit.sv
module rtc_alarm_irq_unit
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [6:0]        cur_sec_i,
  input  logic [6:0]        cur_min_i,
  input  logic [5:0]        cur_hour_i,
  input  logic [4:0]        cur_mon_i,
  input  logic [5:0]        cur_date_i,
  input  logic              tick_i,
  input  logic              upd_ack_i,
  input  logic              sec_ev_i,
  input  logic              time_ev_i,
  input  logic              cal_ev_i,
  output logic              irq_o
);
  logic [WORD_W-1:0] talm_q, calm_q;
  logic              wr;
  logic [NUM_EV-1:0] clr_vec, ien_vec, idis_vec, ev_vec, status, mask;
  logic [NUM_FLD-1:0][7:0] alm_f, cur_f;
  logic [NUM_FLD-1:0] fld_en, fld_bad;
  logic              alm_hit;
  logic [1:0]        vld;

  assign wr = req_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      talm_q <= '0;
      calm_q <= '0;
    end else if (wr) begin
      if (addr_i == ADDR_W'(OFS_TALM)) talm_q <= wdata_i & TALM_MASK;
      if (addr_i == ADDR_W'(OFS_CALM)) calm_q <= wdata_i & CALM_MASK;
    end
  end

  assign clr_vec  = (wr && addr_i == ADDR_W'(OFS_SCLR)) ? wdata_i[NUM_EV-1:0] : '0;
  assign ien_vec  = (wr && addr_i == ADDR_W'(OFS_IEN))  ? wdata_i[NUM_EV-1:0] : '0;
  assign idis_vec = (wr && addr_i == ADDR_W'(OFS_IDIS)) ? wdata_i[NUM_EV-1:0] : '0;

  // field extraction, zero-extended to one BCD byte
  assign alm_f[F_SEC]  = {1'b0, talm_q[6:0]};
  assign alm_f[F_MIN]  = {1'b0, talm_q[14:8]};
  assign alm_f[F_HOUR] = {2'b0, talm_q[21:16]};
  assign alm_f[F_MON]  = {3'b0, calm_q[20:16]};
  assign alm_f[F_DATE] = {2'b0, calm_q[29:24]};
  assign cur_f[F_SEC]  = {1'b0, cur_sec_i};
  assign cur_f[F_MIN]  = {1'b0, cur_min_i};
  assign cur_f[F_HOUR] = {2'b0, cur_hour_i};
  assign cur_f[F_MON]  = {3'b0, cur_mon_i};
  assign cur_f[F_DATE] = {2'b0, cur_date_i};
  assign fld_en = {calm_q[31], calm_q[23], talm_q[23], talm_q[15], talm_q[7]};

  rtc_alarm_cmp #(.NF(NUM_FLD)) u_cmp (
    .alm_f_i (alm_f),
    .cur_f_i (cur_f),
    .en_i    (fld_en),
    .tick_i  (tick_i),
    .hit_o   (alm_hit),
    .bad_o   (fld_bad)
  );

  assign vld = {fld_bad[F_MON] | fld_bad[F_DATE],
                fld_bad[F_SEC] | fld_bad[F_MIN] | fld_bad[F_HOUR]};

  assign ev_vec = {cal_ev_i, time_ev_i, sec_ev_i, alm_hit, upd_ack_i};

  rtc_evt_status #(.NEV(NUM_EV)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (ev_vec),
    .clr_i    (clr_vec),
    .ien_i    (ien_vec),
    .idis_i   (idis_vec),
    .status_o (status),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (int'(addr_i))
      OFS_TALM: rdata_o = talm_q;
      OFS_CALM: rdata_o = calm_q;
      OFS_STAT: rdata_o = {{(WORD_W-NUM_EV){1'b0}}, status};
      OFS_MASK: rdata_o = {{(WORD_W-NUM_EV){1'b0}}, mask};
      OFS_VLD:  rdata_o = {{(WORD_W-2){1'b0}}, vld};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk #(
  parameter int NEV = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NEV-1:0] status,
  input logic [NEV-1:0] mask,
  input logic [NEV-1:0] ev_vec,
  input logic [NEV-1:0] clr_vec,
  input logic [NEV-1:0] ien_vec,
  input logic [4:0]     fld_en,
  input logic           irq_o
);
  // R6
  ev_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_vec != '0) |=> ((status & $past(ev_vec)) == $past(ev_vec)));

  // R6
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status & ~clr_vec) != '0) |=> ((status & $past(status & ~clr_vec)) == $past(status & ~clr_vec)));

  // R7
  clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_vec & ~ev_vec) != '0) |=> ((status & $past(clr_vec & ~ev_vec)) == '0));

  // R5
  no_en_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status[1]) |-> ($past(fld_en) != '0));

  // R8
  ien_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_vec != '0) |=> ((mask & $past(ien_vec)) == $past(ien_vec)));

  // R9
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask == '0) || (status == '0)) |-> !irq_o);
endmodule

bind rtc_alarm_irq_unit rtc_alarm_irq_chk #(.NEV(rtc_alarm_pkg::NUM_EV)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .status  (status),
  .mask    (mask),
  .ev_vec  (ev_vec),
  .clr_vec (clr_vec),
  .ien_vec (ien_vec),
  .fld_en  (fld_en),
  .irq_o   (irq_o)
);

// File: tb/tb_rtc_alarm_irq_unit.sv
`timescale 1ns/1ps
module tb_rtc_alarm_irq_unit;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 0, we = 0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [6:0] csec = '0, cmin = '0;
  logic [5:0] chour = '0, cdate = '0;
  logic [4:0] cmon = '0;
  logic tick = 0, upd = 0, sev = 0, tev = 0, cev = 0, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  rtc_alarm_irq_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cur_sec_i(csec), .cur_min_i(cmin),
    .cur_hour_i(chour), .cur_mon_i(cmon), .cur_date_i(cdate), .tick_i(tick),
    .upd_ack_i(upd), .sec_ev_i(sev), .time_ev_i(tev), .cal_ev_i(cev), .irq_o(irq)
  );

  localparam logic [2:0] A_TALM = 0, A_CALM = 1, A_STAT = 2, A_SCLR = 3,
                         A_IEN = 4, A_IDIS = 5, A_MASK = 6, A_VLD = 7;

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic set_time(logic [5:0] h, logic [6:0] m, logic [6:0] s);
    chour = h; cmin = m; csec = s;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_STAT, d); chk("R1 status", d, 0);
    rd(A_MASK, d); chk("R1 mask", d, 0);
    rd(A_TALM, d); chk("R1 talm", d, 0);
    rd(A_VLD, d);  chk("R1 valid", d, 2);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(A_TALM, 32'hFFFF_FFFF); rd(A_TALM, d); chk("R2 talm readback", d, 32'h00BF_FFFF);
    wr(A_CALM, 32'hFFFF_FFFF); rd(A_CALM, d); chk("R3 calm readback", d, 32'hBF9F_0000);
    rd(A_VLD, d); chk("R10 both bad", d, 3);
    wr(A_TALM, 0); wr(A_CALM, 0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    @(negedge clk); sev = 1; @(negedge clk); sev = 0;
    rd(A_STAT, d); chk("R6 sec ev", d, 32'h04);
    @(negedge clk); cev = 1; @(negedge clk); cev = 0;
    repeat (3) @(negedge clk);
    rd(A_STAT, d); chk("R6 sticky cal+sec", d, 32'h14);
    @(negedge clk); tev = 1; @(negedge clk); tev = 0;
    rd(A_STAT, d); chk("R6 time ev", d, 32'h1C);
    chk("R9 irq masked", {31'b0, irq}, 0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(A_SCLR, 0);     rd(A_STAT, d); chk("R7 zero write", d, 32'h1C);
    wr(A_SCLR, 32'h18); rd(A_STAT, d); chk("R7 clear bits", d, 32'h04);
    @(negedge clk); upd = 1; @(negedge clk); upd = 0;
    rd(A_STAT, d); chk("R6 upd ack", d, 32'h05);
    @(negedge clk); req = 1; we = 1; addr = A_SCLR; wdata = 32'h01; upd = 1;
    @(negedge clk); req = 0; we = 0; upd = 0;
    rd(A_STAT, d); chk("R7 event wins", d, 32'h05);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_IEN, 32'h04); rd(A_MASK, d); chk("R8 ien", d, 32'h04);
    chk("R9 irq on", {31'b0, irq}, 1);
    wr(A_IEN, 32'h02); rd(A_MASK, d); chk("R8 ien keeps", d, 32'h06);
    wr(A_IDIS, 32'h04); rd(A_MASK, d); chk("R8 idis", d, 32'h02);
    chk("R9 irq off", {31'b0, irq}, 0);
    wr(A_SCLR, 32'h1F); rd(A_STAT, d); chk("R7 clear all", d, 0);
  endtask

  task automatic t_alarm_full();
    logic [31:0] d;
    wr(A_TALM, 32'h0088_95B0);  // 08:15:30, all three enabled
    set_time(6'h08, 7'h15, 7'h31); do_tick();
    rd(A_STAT, d); chk("R4 sec mismatch", d, 0);
    set_time(6'h08, 7'h15, 7'h30); repeat (3) @(negedge clk);
    rd(A_STAT, d); chk("R4 no tick", d, 0);
    do_tick();
    rd(A_STAT, d); chk("R4 full match", d, 32'h02);
    chk("R9 alarm irq", {31'b0, irq}, 1);
    set_time(6'h09, 7'h00, 7'h00); do_tick();
    rd(A_STAT, d); chk("R6 alarm sticky", d, 32'h02);
    wr(A_SCLR, 32'h02);
  endtask

  task automatic t_alarm_partial();
    logic [31:0] d;
    wr(A_TALM, 32'h0000_00B0);  // seconds only
    set_time(6'h10, 7'h12, 7'h30); do_tick();
    rd(A_STAT, d); chk("R4 partial match", d, 32'h02);
    wr(A_SCLR, 32'h02);
  endtask

  task automatic t_alarm_cal();
    logic [31:0] d;
    wr(A_TALM, 0);
    wr(A_CALM, 32'h9586_0000);  // month 06, date 15
    cmon = 5'h06; cdate = 6'h16; do_tick();
    rd(A_STAT, d); chk("R4 date mismatch", d, 0);
    cdate = 6'h15; do_tick();
    rd(A_STAT, d); chk("R4 cal match", d, 32'h02);
    wr(A_SCLR, 32'h02);
  endtask

  task automatic t_no_enable();
    logic [31:0] d;
    wr(A_TALM, 32'h0008_1530); wr(A_CALM, 32'h1506_0000);
    set_time(6'h08, 7'h15, 7'h30); cmon = 5'h06; cdate = 6'h15;
    do_tick(); do_tick();
    rd(A_STAT, d); chk("R5 no enables", d, 0);
    chk("R9 irq idle", {31'b0, irq}, 0);
  endtask

  task automatic t_valid();
    logic [31:0] d;
    wr(A_TALM, 32'h0023_5959); wr(A_CALM, 32'h3112_0000);
    rd(A_VLD, d); chk("R10 in range", d, 0);
    wr(A_TALM, 32'h0024_0000); rd(A_VLD, d); chk("R10 hour 24", d, 1);
    wr(A_TALM, 32'h0000_005A); rd(A_VLD, d); chk("R10 sec nonbcd", d, 1);
    wr(A_TALM, 0);
    wr(A_CALM, 32'h3113_0000); rd(A_VLD, d); chk("R10 month 13", d, 2);
    wr(A_CALM, 32'h3212_0000); rd(A_VLD, d); chk("R10 date 32", d, 2);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_layout();
    t_events();
    t_clear();
    t_mask();
    t_alarm_full();
    t_alarm_partial();
    t_alarm_cal();
    t_no_enable();
    t_valid();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule